// File: doc/BRIEF.md
# UART Receive Break Detector

This block watches the character stream of a UART receiver and recognises a line break, meaning a run of characters in which every data bit and the stop position are zero. The receiver gives it one strobe per character, a flag that says whether that character was all zero, and a flag that says a partly filled receive buffer is open. From these inputs the block declares the start of a break, counts how many breaks have occurred, and measures how many characters each break lasted. When the break ends it latches that length.

When a break arrives while a buffer is partly filled, the block issues a close request so that the buffer logic closes the buffer and marks it with a break flag. In synchronous operation with restart-on-zero enabled, one zero character may be a misread start bit. In that mode the block declares a break only after a set number of consecutive zero characters, which is two by default. Three sticky event flags (break start, break end, receive close) are each gated by an enable. They are cleared by writing ones, and a single interrupt line reports whether any flag is set.

Top module: `uart_brk_det`

## Requirements
- R1: After reset every output is zero: pulses, length, count, event flags and interrupt.
- R2: In normal mode the first character strobed with `chr_zero` high while no break is active starts a break. One cycle after that strobe `brk_start` pulses for one cycle and `brk_cnt` has grown by one.
- R3: A break ends on the first strobed character with `chr_zero` low. One cycle after that strobe `brk_end` pulses for one cycle, and `brk_len` then holds the number of zero characters in the run, counting those before the break was declared.
- R4: If `rx_busy` is high on the strobe that declares a break, `close_req` pulses in the same cycle as `brk_start`. If `rx_busy` is low on that strobe, `close_req` stays low.
- R5: When `sync_mode` and `rz_restart` are both high, a break is declared only on the second consecutive zero character. A single zero character followed by a nonzero one raises no event and leaves `brk_cnt` and `brk_len` unchanged.
- R6: The break length counter saturates at 65535 and does not wrap.
- R7: Event flag bit 0 is break start, bit 1 is break end and bit 2 is receive close. A bit becomes set only when its event occurs while its enable (`ie_start`, `ie_end`, `ie_rx`) is high. It stays set until a cycle with `evt_wr` high and a one in that bit of `evt_wdata`. A set in the same cycle wins over a clear.
- R8: `irq` is high exactly when at least one event flag is set.
- R9: `chr_zero` and `rx_busy` have no effect in cycles where `chr_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chr_vld | input | 1 | One-cycle strobe per received character |
| chr_zero | input | 1 | Strobed character was all zero including the stop position |
| rx_busy | input | 1 | A receive buffer is partly filled |
| sync_mode | input | 1 | Synchronous operation selected |
| rz_restart | input | 1 | Restart-on-zero option |
| ie_start | input | 1 | Enable for the break-start flag |
| ie_end | input | 1 | Enable for the break-end flag |
| ie_rx | input | 1 | Enable for the receive-close flag |
| evt_wr | input | 1 | Write strobe for clearing flags |
| evt_wdata | input | 3 | Write-one-to-clear mask |
| brk_start | output | 1 | Break-start pulse |
| brk_end | output | 1 | Break-end pulse |
| close_req | output | 1 | Request to close the open buffer with the break flag |
| brk_len | output | 16 | Length of the last completed break in characters |
| brk_cnt | output | 16 | Number of breaks declared (saturating) |
| evt_flags | output | 3 | Sticky event flags |
| irq | output | 1 | OR of the event flags |

## Verification
Most errors in this block are in the zero-run counter or the in-break state. A wrong run count does not show when it occurs. It shows later, either in `brk_len` when the break ends or as a `brk_start` that comes one character early or late in restart-on-zero mode. A stuck in-break state shows one cycle after the next strobe, as a missing start or end pulse and a `brk_cnt` that does not move. For that reason the bench compares every output against its model on every clock. It also drives runs long enough to reach the saturation limit, and it places single zero characters between nonzero ones.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
   localparam int EV_N = 3;
   typedef enum int {
      EV_START = 0,
      EV_END   = 1,
      EV_RX    = 2
   } brk_ev_e;
endpackage

// File: rtl/brk_run_tracker.sv
module brk_run_tracker #(
   parameter int LEN_W    = 16,
   parameter int RZ_CHARS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chr_vld,
   input  logic             chr_zero,
   input  logic             rx_busy,
   input  logic             sync_mode,
   input  logic             rz_restart,
   output logic             start_c,
   output logic             end_c,
   output logic             close_c,
   output logic             start_p,
   output logic             end_p,
   output logic             close_p,
   output logic [LEN_W-1:0] len_q
);
   localparam logic [LEN_W-1:0] LEN_MAX = '1;
   localparam logic [LEN_W-1:0] NEED_RZ = LEN_W'(RZ_CHARS);
   localparam logic [LEN_W-1:0] NEED_1  = LEN_W'(1);

   logic [LEN_W-1:0] zrun_q;
   logic [LEN_W-1:0] zrun_inc;
   logic [LEN_W-1:0] need;
   logic             in_brk_q;
   logic             rz_mode;

   always_comb begin
      rz_mode  = sync_mode && rz_restart;
      zrun_inc = (zrun_q == LEN_MAX) ? zrun_q : zrun_q + NEED_1;
      need     = rz_mode ? NEED_RZ : NEED_1;
      start_c  = chr_vld && chr_zero && !in_brk_q && (zrun_inc >= need);
      end_c    = chr_vld && !chr_zero && in_brk_q;
      close_c  = start_c && rx_busy;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         zrun_q   <= '0;
         in_brk_q <= 1'b0;
         len_q    <= '0;
         start_p  <= 1'b0;
         end_p    <= 1'b0;
         close_p  <= 1'b0;
      end else begin
         start_p <= start_c;
         end_p   <= end_c;
         close_p <= close_c;
         if (chr_vld) begin
            zrun_q <= chr_zero ? zrun_inc : '0;
         end
         if (start_c) begin
            in_brk_q <= 1'b1;
         end else if (end_c) begin
            in_brk_q <= 1'b0;
         end
         if (end_c) begin
            len_q <= zrun_q;
         end
      end
   end

   AST_RZ_FIRST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (chr_vld && chr_zero && rz_mode && zrun_q == '0 && !in_brk_q) |=> !start_p); // R5
   AST_LEN_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      end_c |=> (len_q != '0)); // R3
   AST_NO_START_IN_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
      start_p |-> !$past(in_brk_q)); // R2
endmodule

// File: rtl/brk_err_counter.sv
module brk_err_counter #(
   parameter int W        = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] ONE = W'(1);
   logic [W-1:0] nxt;

   generate
      if (SATURATE) begin : g_sat
         always_comb nxt = (&cnt) ? cnt : cnt + ONE;
      end else begin : g_wrap
         always_comb nxt = cnt + ONE;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (inc) begin
         cnt <= nxt;
      end
   end

   AST_CNT_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(cnt)); // R2
endmodule

// File: rtl/brk_evt_reg.sv
module brk_evt_reg #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ev,
   input  logic [N-1:0] ie,
   input  logic         wr,
   input  logic [N-1:0] wdata,
   output logic [N-1:0] flags,
   output logic         irq
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               flags[i] <= 1'b0;
            end else if (ev[i] && ie[i]) begin
               flags[i] <= 1'b1;
            end else if (wr && wdata[i]) begin
               flags[i] <= 1'b0;
            end
         end

         AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !(wr && wdata[i])) |=> flags[i]); // R7
         AST_FLAG_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
            (!flags[i] && !ie[i]) |=> !flags[i]); // R7
      end
   endgenerate

   always_comb irq = |flags;
endmodule

// File: rtl/uart_brk_det.sv
module uart_brk_det #(
   parameter int LEN_W    = 16,
   parameter int CNT_W    = 16,
   parameter int RZ_CHARS = 2,
   parameter bit CNT_SAT  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chr_vld,
   input  logic             chr_zero,
   input  logic             rx_busy,
   input  logic             sync_mode,
   input  logic             rz_restart,
   input  logic             ie_start,
   input  logic             ie_end,
   input  logic             ie_rx,
   input  logic             evt_wr,
   input  logic [2:0]       evt_wdata,
   output logic             brk_start,
   output logic             brk_end,
   output logic             close_req,
   output logic [LEN_W-1:0] brk_len,
   output logic [CNT_W-1:0] brk_cnt,
   output logic [2:0]       evt_flags,
   output logic             irq
);
   import uart_brk_pkg::*;

   generate
      if (LEN_W < 2 || LEN_W > 32) begin : g_bad_len
         $error("LEN_W out of range");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("CNT_W out of range");
      end
      if (RZ_CHARS < 1 || RZ_CHARS >= (1 << (LEN_W - 1))) begin : g_bad_rz
         $error("RZ_CHARS out of range");
      end
   endgenerate

   logic            start_c, end_c, close_c;
   logic [EV_N-1:0] ev_vec, ie_vec;

   brk_run_tracker #(.LEN_W(LEN_W), .RZ_CHARS(RZ_CHARS)) u_trk (
      .clk(clk), .rst_n(rst_n), .chr_vld(chr_vld), .chr_zero(chr_zero),
      .rx_busy(rx_busy), .sync_mode(sync_mode), .rz_restart(rz_restart),
      .start_c(start_c), .end_c(end_c), .close_c(close_c),
      .start_p(brk_start), .end_p(brk_end), .close_p(close_req),
      .len_q(brk_len)
   );

   brk_err_counter #(.W(CNT_W), .SATURATE(CNT_SAT)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(start_c), .cnt(brk_cnt)
   );

   always_comb begin
      ev_vec           = '0;
      ie_vec           = '0;
      ev_vec[EV_START] = start_c;
      ev_vec[EV_END]   = end_c;
      ev_vec[EV_RX]    = close_c;
      ie_vec[EV_START] = ie_start;
      ie_vec[EV_END]   = ie_end;
      ie_vec[EV_RX]    = ie_rx;
   end

   brk_evt_reg #(.N(EV_N)) u_evt (
      .clk(clk), .rst_n(rst_n), .ev(ev_vec), .ie(ie_vec),
      .wr(evt_wr), .wdata(evt_wdata), .flags(evt_flags), .irq(irq)
   );

   AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(brk_start && brk_end)); // R3
   AST_CLOSE_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
      close_req |-> brk_start); // R4
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      brk_start |-> ((brk_cnt == $past(brk_cnt) + CNT_W'(1)) || (&$past(brk_cnt)))); // R2
   AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      !chr_vld |=> !(brk_start || brk_end || close_req)); // R9
   AST_IRQ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_flags != 3'b000) |-> irq); // R8
endmodule

// File: tb/uart_brk_det_test.sv
module uart_brk_det_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chr_vld = 1'b0, chr_zero = 1'b0, rx_busy = 1'b0;
   logic        sync_mode = 1'b0, rz_restart = 1'b0;
   logic        ie_start = 1'b0, ie_end = 1'b0, ie_rx = 1'b0;
   logic        evt_wr = 1'b0;
   logic [2:0]  evt_wdata = 3'b000;
   logic        brk_start, brk_end, close_req, irq;
   logic [15:0] brk_len, brk_cnt;
   logic [2:0]  evt_flags;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   // reference model state
   int          m_zrun = 0;
   bit          m_inb = 1'b0;
   logic [15:0] m_len = '0, m_cnt = '0;
   logic        m_start = 1'b0, m_end = 1'b0, m_close = 1'b0;
   logic [2:0]  m_flags = '0;

   always #5 clk = ~clk;

   uart_brk_det uut (
      .clk(clk), .rst_n(rst_n), .chr_vld(chr_vld), .chr_zero(chr_zero),
      .rx_busy(rx_busy), .sync_mode(sync_mode), .rz_restart(rz_restart),
      .ie_start(ie_start), .ie_end(ie_end), .ie_rx(ie_rx),
      .evt_wr(evt_wr), .evt_wdata(evt_wdata),
      .brk_start(brk_start), .brk_end(brk_end), .close_req(close_req),
      .brk_len(brk_len), .brk_cnt(brk_cnt), .evt_flags(evt_flags), .irq(irq)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic model_step();
      int need;
      logic [2:0] ev;
      m_start = 1'b0; m_end = 1'b0; m_close = 1'b0;
      if (chr_vld) begin
         if (chr_zero) begin
            if (m_zrun < 65535) m_zrun++;
            need = (sync_mode && rz_restart) ? 2 : 1;
            if (!m_inb && m_zrun >= need) begin
               m_inb = 1'b1;
               m_start = 1'b1;
               if (m_cnt != 16'hFFFF) m_cnt++;
               m_close = rx_busy;
            end
         end else begin
            if (m_inb) begin
               m_len = 16'(m_zrun);
               m_end = 1'b1;
               m_inb = 1'b0;
            end
            m_zrun = 0;
         end
      end
      ev = {m_close & ie_rx, m_end & ie_end, m_start & ie_start};
      if (evt_wr) m_flags = m_flags & ~evt_wdata;
      m_flags = m_flags | ev;
   endtask

   task automatic compare_all();
      chk("R2", 32'(brk_start), 32'(m_start), "brk_start");
      chk("R2", 32'(brk_cnt), 32'(m_cnt), "brk_cnt");
      chk("R3", 32'(brk_end), 32'(m_end), "brk_end");
      chk("R3", 32'(brk_len), 32'(m_len), "brk_len");
      chk("R4", 32'(close_req), 32'(m_close), "close_req");
      chk("R7", 32'(evt_flags), 32'(m_flags), "evt_flags");
      chk("R8", 32'(irq), 32'(m_flags != 3'b000), "irq");
   endtask

   // at negedge: drive, wait posedge, model, wait negedge, compare
   task automatic cyc(logic v, logic z, logic b, logic w, logic [2:0] wd);
      chr_vld = v; chr_zero = z; rx_busy = b; evt_wr = w; evt_wdata = wd;
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_all();
   endtask

   task automatic chr(logic z, logic b);
      cyc(1'b1, z, b, 1'b0, 3'b000);
   endtask

   initial begin
      logic [15:0] cnt_before, len_before;
      @(negedge clk);
      @(negedge clk);
      // R1: reset state
      chk("R1", 32'({brk_start, brk_end, close_req, irq}), 32'h0, "pulses/irq");
      chk("R1", 32'(brk_len), 32'h0, "brk_len");
      chk("R1", 32'(brk_cnt), 32'h0, "brk_cnt");
      chk("R1", 32'(evt_flags), 32'h0, "evt_flags");
      rst_n = 1'b1;
      ie_start = 1'b1; ie_end = 1'b1; ie_rx = 1'b1;

      // R2/R3: normal break of three characters, not busy
      chr(1'b0, 1'b0);
      chr(1'b1, 1'b0);
      chk("R2", 32'(brk_start), 32'h1, "start after first zero");
      chr(1'b1, 1'b0);
      chr(1'b1, 1'b0);
      chr(1'b0, 1'b0);
      chk("R3", 32'(brk_len), 32'd3, "length of 3-char break");

      // R4: break while busy
      chr(1'b1, 1'b1);
      chk("R4", 32'(close_req), 32'h1, "close with busy");
      chr(1'b0, 1'b1);

      // R7: clear all, set wins over clear
      cyc(1'b0, 1'b0, 1'b0, 1'b1, 3'b111);
      chk("R7", 32'(evt_flags), 32'h0, "cleared");
      chr(1'b1, 1'b0);
      cyc(1'b1, 1'b0, 1'b0, 1'b1, 3'b011);
      chk("R7", 32'(evt_flags), 32'b010, "set wins over clear");

      // R9: no strobe, zero and busy ignored
      cnt_before = brk_cnt;
      repeat (5) cyc(1'b0, 1'b1, 1'b1, 1'b0, 3'b000);
      chk("R9", 32'(brk_cnt), 32'(cnt_before), "no strobe no count");
      chk("R9", 32'(brk_start), 32'h0, "no strobe no start");

      // R5: restart-on-zero mode
      sync_mode = 1'b1; rz_restart = 1'b1;
      cnt_before = brk_cnt; len_before = brk_len;
      chr(1'b1, 1'b1);
      chr(1'b0, 1'b1);
      chk("R5", 32'(brk_cnt), 32'(cnt_before), "single zero no break");
      chk("R5", 32'(brk_len), 32'(len_before), "single zero len kept");
      chr(1'b1, 1'b1);
      chk("R5", 32'(brk_start), 32'h0, "no start on first zero");
      chr(1'b1, 1'b1);
      chk("R5", 32'(brk_start), 32'h1, "start on second zero");
      chr(1'b0, 1'b0);
      chk("R5", 32'(brk_len), 32'd2, "rz length");
      sync_mode = 1'b0; rz_restart = 1'b0;

      // R7: masked events do not set
      ie_start = 1'b0; ie_end = 1'b0; ie_rx = 1'b0;
      cyc(1'b0, 1'b0, 1'b0, 1'b1, 3'b111);
      chr(1'b1, 1'b1);
      chr(1'b0, 1'b0);
      chk("R7", 32'(evt_flags), 32'h0, "masked events");

      // R6: saturation of length
      ie_start = 1'b1; ie_end = 1'b1; ie_rx = 1'b1;
      for (int i = 0; i < 65540; i++) chr(1'b1, 1'b0);
      chr(1'b0, 1'b0);
      chk("R6", 32'(brk_len), 32'hFFFF, "saturated length");

      // mixed stimulus
      for (int i = 0; i < 4000; i++) begin
         if (($urandom % 64) == 0) sync_mode = 1'($urandom);
         if (($urandom % 64) == 0) rz_restart = 1'($urandom);
         if (($urandom % 32) == 0) {ie_start, ie_end, ie_rx} = 3'($urandom);
         cyc(1'(($urandom % 4) != 0), 1'(($urandom % 3) != 0), 1'($urandom),
             1'(($urandom % 8) == 0), 3'($urandom));
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end
endmodule